// File: doc/BRIEF.md
# Pad Configuration Chain Driver

This block sets up a ring of pad control cells that are wired end to end as one long serial shift register. Each cell takes a 13-bit configuration word. The driver keeps one such word per cell and exposes a plain write strobe, so the words can be changed at any time while it is idle. A start pulse makes the driver shift every word onto the chain. The serial clock it generates comes from the system clock through a run-time divider. Once the last bit is in place, the driver makes all cells commit their shift contents at the same time.

The chain has no dedicated load or clear wire. Both commands travel on the shared active-low chain reset. The level of the serial clock at the moment reset is low picks which one it is:

- Reset low with the clock high copies each cell's shift contents into its configuration latches (load).
- Reset low with the clock low clears the shift registers and restores each cell's default configuration (clear).

The driver orders the clock and reset edges so that a load can never turn into a clear. It also applies a clear by itself after every system reset, which puts every cell in its default state. A busy flag covers the power-up clear and every transfer. A one-cycle done pulse marks the end of each commit.

Top module: `padcfg_chain_drv`

## Requirements
- R1: After system reset, `chain_rst_n` and `chain_sclk` stay low for 4 half serial periods (two full periods), which is 4*(`half_div`+1) system cycles. `busy` is high during this time. Then `chain_rst_n` rises and `busy` falls in the same cycle, and every cell holds its default word.
- R2: The word layout is as follows:
  - bit 0: management ownership
  - bit 1: output-enable-bar
  - bit 2: hold
  - bit 3: input disable
  - bit 4: input buffer mode
  - bits 5, 6, 7: analog enable, analog select, analog polarity
  - bit 8: slow slew
  - bit 9: trip select
  - bits 12:10: drive mode

  The default word is 13'h403 (ownership 1, output-enable-bar 1, drive mode 3'b001, all other bits 0). System reset loads the default word into every stored word.
- R3: A start while idle gives exactly NUM_CELLS*13 rising edges of `chain_sclk`. Word NUM_CELLS-1 goes out first and word 0 goes out last. Each word is sent from bit 12 down to bit 0. As a result, the cell at chain position k latches stored word k.
- R4: The commit runs in this order:
  1. `chain_sclk` stays high after the last rising data edge.
  2. `chain_rst_n` is low for `half_div`+1 cycles.
  3. `chain_rst_n` returns high.
  4. Only after that does `chain_sclk` fall.

  `chain_sclk` never falls while `chain_rst_n` is low. A clock that falls while reset is low clears the chain.
- R5: Each half period of `chain_sclk` lasts `half_div`+1 system cycles, so rising edges are 2*(`half_div`+1) cycles apart. `chain_sdata` changes only while `chain_sclk` is low.
- R6: A write is ignored if it arrives while `busy` is high or in the same cycle as `start`.
- R7: A `start` while `busy` is high is ignored. The current transfer still gives exactly NUM_CELLS*13 edges, and no second transfer follows.
- R8: `done` is high for exactly one cycle, the cycle in which `busy` falls after a commit. At that point `chain_sclk` is low and `chain_rst_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Word write strobe |
| cfg_addr | input | ADDR_W | Cell index of the word written |
| cfg_wdata | input | 13 | Word to store |
| half_div | input | DIV_W | Half serial period minus one, in system cycles |
| start | input | 1 | Begin a transfer and commit |
| chain_sclk | output | 1 | Serial clock to the chain |
| chain_sdata | output | 1 | Serial data into the first cell |
| chain_rst_n | output | 1 | Shared active-low reset, also carries load and clear |
| busy | output | 1 | Power-up clear or transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a commit |

## Verification
The assertions assume that `half_div` does not change during a power-up clear or a transfer. If it did, a half period could stretch across a counter wrap, and the edge spacing and the order of the commit edges would no longer follow the stated count. The bench changes `half_div` only while `busy` is low. It drives every other input half a cycle away from the active edge. The cells are modelled asynchronously from the stated load and clear encoding. This lets the bench catch a commit that turns into a clear.

// File: rtl/padcfg_pkg.sv
package padcfg_pkg;

    localparam int CFG_BITS = 13;
    localparam int BIT_W    = $clog2(CFG_BITS);

    // Field order is what the cells decode, bit 12 down to bit 0.
    typedef struct packed {
        logic [2:0] drive_mode;  // 12:10
        logic       trip_sel;    // 9
        logic       slew_slow;   // 8
        logic       ana_pol;     // 7
        logic       ana_sel;     // 6
        logic       ana_en;      // 5
        logic       ibuf_mode;   // 4
        logic       in_off;      // 3
        logic       hold;        // 2
        logic       out_en_n;    // 1
        logic       mgmt_own;    // 0
    } pad_cfg_t;

    typedef enum logic [2:0] {
        ST_INIT,
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_LOAD,
        ST_RELEASE
    } seq_state_t;

    typedef struct packed {
        logic sclk;
        logic sdata;
        logic rst_n;
    } chain_pins_t;

    function automatic pad_cfg_t cfg_default();
        pad_cfg_t w;
        w            = '0;
        w.mgmt_own   = 1'b1;
        w.out_en_n   = 1'b1;
        w.drive_mode = 3'b001;
        return w;
    endfunction

endpackage

// File: rtl/padcfg_store.sv
module padcfg_store
    import padcfg_pkg::*;
#(
    parameter int NUM_CELLS = 4,
    parameter int ADDR_W    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  pad_cfg_t          wdata,
    input  logic              lock,
    input  logic [ADDR_W-1:0] rd_idx,
    output pad_cfg_t          rd_word
);

    pad_cfg_t words [NUM_CELLS];

    generate
        for (genvar g = 0; g < NUM_CELLS; g++) begin : g_word
            always_ff @(posedge clk) begin
                if (rst) begin
                    words[g] <= cfg_default();
                end else if (we && !lock && (waddr == ADDR_W'(g))) begin
                    words[g] <= wdata;
                end
            end
        end
    endgenerate

    always_comb begin
        if (32'(rd_idx) < NUM_CELLS) begin
            rd_word = words[rd_idx];
        end else begin
            rd_word = cfg_default();
        end
    end

endmodule

// File: rtl/padcfg_divider.sv
module padcfg_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == half_div);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/padcfg_sequencer.sv
module padcfg_sequencer
    import padcfg_pkg::*;
#(
    parameter int NUM_CELLS   = 4,
    parameter int ADDR_W      = 2,
    parameter int INIT_HALVES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              tick,
    input  pad_cfg_t          word,
    output logic [ADDR_W-1:0] rd_idx,
    output logic              run,
    output chain_pins_t       pins,
    output logic              busy,
    output logic              done
);

    localparam int HALF_W = $clog2(INIT_HALVES) + 1;
    localparam logic [BIT_W-1:0]  TOP_BIT  = BIT_W'(CFG_BITS - 1);
    localparam logic [ADDR_W-1:0] TOP_CELL = ADDR_W'(NUM_CELLS - 1);

    seq_state_t         state;
    logic [BIT_W-1:0]   bit_idx, nxt_bit;
    logic [ADDR_W-1:0]  cell_idx, nxt_cell;
    logic [HALF_W-1:0]  half_cnt;
    logic [CFG_BITS-1:0] wbits;
    logic               last_bit;

    assign wbits    = word;
    assign last_bit = (bit_idx == '0) && (cell_idx == '0);
    assign run      = (state != ST_IDLE);
    assign busy     = (state != ST_IDLE);
    assign rd_idx   = nxt_cell;

    // Index of the next bit to drive: farthest cell first, MSB first.
    always_comb begin
        if (state == ST_IDLE) begin
            nxt_bit  = TOP_BIT;
            nxt_cell = TOP_CELL;
        end else if (bit_idx == '0) begin
            nxt_bit  = TOP_BIT;
            nxt_cell = cell_idx - 1'b1;
        end else begin
            nxt_bit  = bit_idx - 1'b1;
            nxt_cell = cell_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_INIT;
            pins.sclk  <= 1'b0;
            pins.sdata <= 1'b0;
            pins.rst_n <= 1'b0;
            half_cnt   <= '0;
            bit_idx    <= TOP_BIT;
            cell_idx   <= TOP_CELL;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_INIT: begin
                    if (tick) begin
                        if (half_cnt == HALF_W'(INIT_HALVES - 1)) begin
                            pins.rst_n <= 1'b1;
                            state      <= ST_IDLE;
                        end else begin
                            half_cnt <= half_cnt + 1'b1;
                        end
                    end
                end
                ST_IDLE: begin
                    if (start) begin
                        bit_idx    <= nxt_bit;
                        cell_idx   <= nxt_cell;
                        pins.sdata <= wbits[nxt_bit];
                        state      <= ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (tick) begin
                        pins.sclk <= 1'b1;
                        state     <= ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (tick) begin
                        if (last_bit) begin
                            pins.rst_n <= 1'b0;
                            state      <= ST_LOAD;
                        end else begin
                            pins.sclk  <= 1'b0;
                            bit_idx    <= nxt_bit;
                            cell_idx   <= nxt_cell;
                            pins.sdata <= wbits[nxt_bit];
                            state      <= ST_LOW;
                        end
                    end
                end
                ST_LOAD: begin
                    if (tick) begin
                        pins.rst_n <= 1'b1;
                        state      <= ST_RELEASE;
                    end
                end
                ST_RELEASE: begin
                    if (tick) begin
                        pins.sclk <= 1'b0;
                        bit_idx   <= TOP_BIT;
                        cell_idx  <= TOP_CELL;
                        done      <= 1'b1;
                        state     <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/padcfg_chain_drv.sv
module padcfg_chain_drv
    import padcfg_pkg::*;
#(
    parameter int NUM_CELLS   = 4,
    parameter int DIV_W       = 8,
    parameter int INIT_HALVES = 4,
    parameter int ADDR_W      = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [CFG_BITS-1:0] cfg_wdata,
    input  logic [DIV_W-1:0]    half_div,
    input  logic                start,
    output logic                chain_sclk,
    output logic                chain_sdata,
    output logic                chain_rst_n,
    output logic                busy,
    output logic                done
);

    pad_cfg_t          rd_word;
    logic [ADDR_W-1:0] rd_idx;
    logic              run;
    logic              tick;
    logic              seq_busy;
    chain_pins_t       pins;

    padcfg_store #(
        .NUM_CELLS (NUM_CELLS),
        .ADDR_W    (ADDR_W)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .waddr   (cfg_addr),
        .wdata   (pad_cfg_t'(cfg_wdata)),
        .lock    (seq_busy | start),
        .rd_idx  (rd_idx),
        .rd_word (rd_word)
    );

    padcfg_divider #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .half_div (half_div),
        .tick     (tick)
    );

    padcfg_sequencer #(
        .NUM_CELLS   (NUM_CELLS),
        .ADDR_W      (ADDR_W),
        .INIT_HALVES (INIT_HALVES)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .tick   (tick),
        .word   (rd_word),
        .rd_idx (rd_idx),
        .run    (run),
        .pins   (pins),
        .busy   (seq_busy),
        .done   (done)
    );

    assign chain_sclk  = pins.sclk;
    assign chain_sdata = pins.sdata;
    assign chain_rst_n = pins.rst_n;
    assign busy        = seq_busy;

endmodule

// File: rtl/padcfg_chain_drv_chk.sv
module padcfg_chain_drv_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic chain_sclk,
    input logic chain_sdata,
    input logic chain_rst_n,
    input logic busy,
    input logic done
);

    // R4
    sclk_fall_rst_high_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(chain_sclk) |-> chain_rst_n);

    // R4
    load_keeps_clock_chk: assert property (@(posedge clk) disable iff (rst)
        (chain_sclk && !chain_rst_n) |=> chain_sclk);

    // R5
    data_moves_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(chain_sdata) |-> !chain_sclk);

    // R1
    chain_reset_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !chain_rst_n |-> busy);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    done_at_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !chain_sclk && chain_rst_n && $past(busy)));

    // R7
    start_busy_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !done) |=> (busy || done));

endmodule

bind padcfg_chain_drv padcfg_chain_drv_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .chain_sclk  (chain_sclk),
    .chain_sdata (chain_sdata),
    .chain_rst_n (chain_rst_n),
    .busy        (busy),
    .done        (done)
);

// File: tb/padcfg_chain_drv_bench.sv
module padcfg_chain_drv_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NUM = 4;
    localparam int AW = 2;
    localparam int DW = 8;
    localparam logic [12:0] DEF_WORD = 13'h403;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_we;
    logic [AW-1:0] cfg_addr;
    logic [12:0]   cfg_wdata;
    logic [DW-1:0] half_div;
    logic          start;
    logic          chain_sclk, chain_sdata, chain_rst_n, busy, done;

    always #(CLK_PERIOD/2) clk = ~clk;

    padcfg_chain_drv #(.NUM_CELLS(NUM), .DIV_W(DW)) u_padcfg_chain_drv (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .half_div(half_div), .start(start),
        .chain_sclk(chain_sclk), .chain_sdata(chain_sdata),
        .chain_rst_n(chain_rst_n), .busy(busy), .done(done)
    );

    int tests = 0;
    int fails = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Cell ring model built from the load/clear encoding.
    logic ovr = 1'b0;
    logic o_sclk = 1'b0, o_sdata = 1'b0, o_rst_n = 1'b1;
    wire  m_sclk  = ovr ? o_sclk  : chain_sclk;
    wire  m_sdata = ovr ? o_sdata : chain_sdata;
    wire  m_rst_n = ovr ? o_rst_n : chain_rst_n;
    wire  m_clr   = !m_rst_n && !m_sclk;
    wire  m_ld    = !m_rst_n && m_sclk;
    logic [12:0] sr  [NUM];
    logic [12:0] cfg [NUM];

    always @(posedge m_sclk or posedge m_clr) begin
        if (m_clr) begin
            for (int i = 0; i < NUM; i++) sr[i] <= '0;
        end else begin
            for (int i = NUM - 1; i > 0; i--) sr[i] <= {sr[i][11:0], sr[i-1][12]};
            sr[0] <= {sr[0][11:0], m_sdata};
        end
    end

    always @(posedge m_ld or posedge m_clr) begin
        if (m_clr) begin
            for (int i = 0; i < NUM; i++) cfg[i] <= DEF_WORD;
        end else begin
            for (int i = 0; i < NUM; i++) cfg[i] <= sr[i];
        end
    end

    // Edge counting and spacing of the serial clock.
    int  edges = 0;
    int  edge_base = 0;
    int  gap = 0;
    longint t_prev = 0;
    always @(posedge chain_sclk) begin
        if (edges > 0) gap = int'(($time - t_prev) / CLK_PERIOD);
        t_prev = $time;
        edges++;
    end

    // Scoreboard
    logic [12:0] exp_q [$];
    logic [12:0] shadow [NUM];

    always @(negedge clk) begin
        if (done) begin
            for (int i = 0; i < NUM; i++) begin
                logic [12:0] e;
                e = exp_q.pop_front();
                chk("R3", $sformatf("cell %0d latched word", i), 32'(cfg[i]), 32'(e));
            end
            chk("R3", "rising edge count", 32'(edges - edge_base), 32'(NUM * 13));
            chk("R5", "rising edge spacing", 32'(gap), 32'(2 * (half_div + 1)));
            chk("R8", "busy low with done", 32'(busy), 32'd0);
            chk("R8", "clock low, reset high at done", {30'd0, chain_sclk, chain_rst_n}, 32'd1);
            @(negedge clk);
            chk("R8", "done width", 32'(done), 32'd0);
        end
    end

    task automatic write_word(input int idx, input logic [12:0] w, input bit accepted);
        cfg_we    = 1'b1;
        cfg_addr  = AW'(idx);
        cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
        if (accepted) shadow[idx] = w;
    endtask

    task automatic kick();
        for (int i = 0; i < NUM; i++) exp_q.push_back(shadow[i]);
        edge_base = edges;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        int n;
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        half_div = 8'd1; start = 1'b0;
        for (int i = 0; i < NUM; i++) shadow[i] = DEF_WORD;
        repeat (3) @(negedge clk);
        chk("R1", "busy in reset", 32'(busy), 32'd1);
        chk("R1", "chain reset and clock low in reset", {30'd0, chain_rst_n, chain_sclk}, 32'd0);
        rst = 1'b0;
        n = 0;
        while (!chain_rst_n && n < 100) begin
            @(negedge clk);
            n++;
            if (!chain_rst_n) chk("R1", "clock low during clear", 32'(chain_sclk), 32'd0);
        end
        chk("R1", "power-up clear length", 32'(n), 32'(4 * (half_div + 1)));
        chk("R1", "busy released with chain reset", 32'(busy), 32'd0);
        for (int i = 0; i < NUM; i++)
            chk("R1", $sformatf("cell %0d default", i), 32'(cfg[i]), 32'(DEF_WORD));

        // R2: stored words start at the default
        kick();
        wait_done();

        // R3: distinct words, fastest clock
        half_div = 8'd0;
        write_word(0, 13'h1555, 1'b1);
        write_word(1, 13'h0AAA, 1'b1);
        write_word(2, 13'h1F01, 1'b1);
        write_word(3, 13'h00FE, 1'b1);
        kick();
        wait_done();
        chk("R2", "cell 2 drive mode field", 32'(cfg[2][12:10]), 32'd7);
        chk("R2", "cell 3 ownership bit", 32'(cfg[3][0]), 32'd0);

        // R6, R7: writes and a start during a transfer
        half_div = 8'd3;
        write_word(0, 13'h0123, 1'b1);
        write_word(1, 13'h1ABC, 1'b1);
        kick();
        repeat (20) @(negedge clk);
        write_word(1, 13'h0000, 1'b0);    // R6 ignored while busy
        start = 1'b1;                     // R7 ignored while busy
        @(negedge clk);
        start = 1'b0;
        wait_done();
        repeat (4) @(negedge clk);
        chk("R7", "no second transfer", 32'(busy), 32'd0);
        chk("R7", "no extra edges", 32'(edges - edge_base), 32'(NUM * 13));

        // R6: write in the start cycle is ignored; rerun shows stored words
        half_div = 8'd1;
        cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 13'h0F0F;
        for (int i = 0; i < NUM; i++) exp_q.push_back(shadow[i]);
        edge_base = edges;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0; cfg_we = 1'b0;
        wait_done();
        chk("R6", "cell 1 kept after busy write", 32'(cfg[1]), 32'h1ABC);

        // R4: load then clock falling under reset clears the ring
        ovr = 1'b1; o_rst_n = 1'b1; o_sclk = 1'b0; o_sdata = 1'b1;
        for (int k = 0; k < 13; k++) begin
            #(CLK_PERIOD) o_sclk = 1'b1;
            #(CLK_PERIOD) o_sclk = 1'b0;
        end
        #(CLK_PERIOD) o_sclk = 1'b1;
        #(CLK_PERIOD) o_rst_n = 1'b0;
        #(CLK_PERIOD);
        chk("R4", "ordered load takes shift contents", 32'(cfg[0]), 32'h1FFF);
        o_sclk = 1'b0;
        #(CLK_PERIOD);
        for (int i = 0; i < NUM; i++)
            chk("R4", $sformatf("cell %0d cleared by misordered fall", i), 32'(cfg[i]), 32'(DEF_WORD));
        o_rst_n = 1'b1;
        ovr = 1'b0;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule